// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Steering Sequencer

This block is the memory-access stage of a generated compute core. When started, it forms an effective address, either from a base register plus a sign-extended immediate or from a base register plus an index register. It then places byte, halfword or word data onto a 32-bit memory bus that has four byte-write enables. The stage issues one access and holds it on the bus until memory signals ready. It then releases the bus and reports completion.

For stores, narrow data is copied across every lane of the write bus, and only the write-enable mask selects which bytes memory updates. For loads, the addressed lane is picked out of the read bus by a bit offset computed from the low address bits. That lane is zero-extended to a full word. Word accesses use the whole bus and assume a 4-byte-aligned address.

Top module: `lane_steer_seq`

## Requirements
- R1: After a start, the address bus carries base plus the immediate, sign-extended from IMM_W bits, when the immediate-select input is 1. It carries base plus the index register when that input is 0. Both sums wrap modulo 2^32.
- R2: A byte store (width code 0) drives the low byte of the store data on all four byte lanes. Its write-enable bit is set at the position given by address bits [1:0], and no other bit is set.
- R3: A halfword store (width code 1) drives the low halfword on both halves of the write bus. Its write enables are 4'b0011 when address bit 1 is 0 and 4'b1100 when address bit 1 is 1.
- R4: A word store (width code 2, and also code 3) drives the full store data and sets all write enables to 4'b1111.
- R5: A load asserts the read strobe with all write enables at zero. A store leaves the read strobe low.
- R6: While memory ready is low, the address, the read strobe and the write enables hold their values.
- R7: A byte load returns byte lane address[1:0] of the read bus, taken from bits offset+7 down to offset with offset = address[1:0]*8, zero-extended to 32 bits.
- R8: A halfword load returns the half of the read bus chosen by address bit 1 (bits 31:16 when it is 1), zero-extended to 32 bits.
- R9: A word load returns the whole read bus.
- R10: In the cycle after the clock edge that samples memory ready high, both strobes are deasserted, the loaded value is valid, and done is high for exactly that one cycle.
- R11: When no access is pending, the read strobe and the write enables are zero. A start that arrives while an access is pending has no effect.
- R12: After reset, the address, the write enables, the read strobe, done and the loaded value are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an access using the operand inputs |
| baseReg | input | 32 | Base register value |
| useImm | input | 1 | 1: add the immediate, 0: add the index register |
| immVal | input | IMM_W (16) | Signed immediate offset |
| idxReg | input | 32 | Index register value |
| storeData | input | 32 | Store source register |
| accWidth | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| isWrite | input | 1 | 1 store, 0 load |
| memRdy | input | 1 | Memory ready handshake |
| memRdata | input | 32 | Memory read bus |
| memAddr | output | 32 | Effective address |
| memWdata | output | 32 | Steered write data |
| memRd | output | 1 | Read strobe |
| memWe | output | 4 | Per-byte write enables |
| loadData | output | 32 | Zero-extended loaded value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that memory raises ready only while an access is pending. They also assume that word accesses use 4-byte-aligned addresses, so that the write-enable shapes are limited to the legal one-hot, paired or full patterns. The stimulus drives ready only after it has seen the strobes it started, and it lowers ready again in the cycle after the access completes. Every word address the stimulus forms has its low two bits clear. A simple word-organized memory model in the bench applies the write enables lane by lane, so that later loads read back what each store steered.

// File: rtl/lane_pkg.sv
package lane_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } accWidth_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic launch;    // capture operands, drive the bus
    logic complete;  // ready seen: release the bus, capture load lane
  } seqCtrl_t;

endpackage

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
  import lane_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     memRdy,
  output seqCtrl_t ctrl,
  output logic     done
);

  seqState_t stateQ, stateNext;

  always_comb begin
    ctrl          = '0;
    stateNext     = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctrl.launch = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (memRdy) begin
          ctrl.complete = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateNext;
      done   <= ctrl.complete;
    end
  end

endmodule

// File: rtl/lane_steer_dp.sv
module lane_steer_dp
  import lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic [DATA_W-1:0] baseReg,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [DATA_W-1:0] idxReg,
  input  logic [DATA_W-1:0] storeData,
  input  logic [1:0]        accWidth,
  input  logic              isWrite,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRd,
  output logic [DATA_W/8-1:0] memWe,
  output logic [DATA_W-1:0] loadData
);

  localparam int LANES      = DATA_W / 8;
  localparam int HALF_LANES = LANES / 2;
  localparam int SEL_W      = $clog2(LANES);

  // ---------------- address formation ----------------
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] offsetOperand;
  logic [DATA_W-1:0] effAddr;

  assign immExt        = {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal};
  assign offsetOperand = useImm ? immExt : idxReg;
  assign effAddr       = baseReg + offsetOperand;

  logic [SEL_W-1:0] byteSel;
  logic [SEL_W-2:0] halfSel;
  assign byteSel = effAddr[SEL_W-1:0];
  assign halfSel = effAddr[SEL_W-1:1];

  // ---------------- store steering ----------------
  logic [DATA_W-1:0] byteRep;
  logic [DATA_W-1:0] halfRep;

  for (genvar g = 0; g < LANES; g++) begin : g_byteRep
    assign byteRep[8*g +: 8] = storeData[7:0];
  end

  for (genvar h = 0; h < HALF_LANES; h++) begin : g_halfRep
    assign halfRep[16*h +: 16] = storeData[15:0];
  end

  logic [LANES-1:0]  weNext;
  logic [DATA_W-1:0] wdNext;

  always_comb begin
    case (accWidth_t'(accWidth))
      ACC_BYTE: begin
        weNext = LANES'(1) << byteSel;
        wdNext = byteRep;
      end
      ACC_HALF: begin
        weNext = LANES'(2'b11) << {halfSel, 1'b0};
        wdNext = halfRep;
      end
      default: begin
        weNext = '1;
        wdNext = storeData;
      end
    endcase
  end

  // ---------------- load extraction ----------------
  logic [DATA_W-1:0] byteShift;
  logic [DATA_W-1:0] halfShift;
  logic [DATA_W-1:0] loadNext;
  logic [1:0]        widthQ;

  assign byteShift = memRdata >> {memAddr[SEL_W-1:0], 3'b000};
  assign halfShift = memRdata >> {memAddr[SEL_W-1:1], 4'b0000};

  always_comb begin
    case (accWidth_t'(widthQ))
      ACC_BYTE: loadNext = {{(DATA_W-8){1'b0}},  byteShift[7:0]};
      ACC_HALF: loadNext = {{(DATA_W-16){1'b0}}, halfShift[15:0]};
      default:  loadNext = memRdata;
    endcase
  end

  // ---------------- bus and result registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memWdata <= '0;
      memRd    <= 1'b0;
      memWe    <= '0;
      widthQ   <= 2'd0;
      loadData <= '0;
    end else if (ctrl.launch) begin
      memAddr  <= effAddr;
      memWdata <= isWrite ? wdNext : '0;
      memRd    <= !isWrite;
      memWe    <= isWrite ? weNext : '0;
      widthQ   <= accWidth;
    end else if (ctrl.complete) begin
      memRd    <= 1'b0;
      memWe    <= '0;
      if (memRd) loadData <= loadNext;
    end
  end

endmodule

// File: rtl/lane_steer_seq.sv
module lane_steer_seq
  import lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [DATA_W-1:0]   baseReg,
  input  logic                useImm,
  input  logic [IMM_W-1:0]    immVal,
  input  logic [DATA_W-1:0]   idxReg,
  input  logic [DATA_W-1:0]   storeData,
  input  logic [1:0]          accWidth,
  input  logic                isWrite,
  input  logic                memRdy,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memRd,
  output logic [DATA_W/8-1:0] memWe,
  output logic [DATA_W-1:0]   loadData,
  output logic                done
);

  seqCtrl_t ctrl;

  lane_steer_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .memRdy (memRdy),
    .ctrl   (ctrl),
    .done   (done)
  );

  lane_steer_dp #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .baseReg   (baseReg),
    .useImm    (useImm),
    .immVal    (immVal),
    .idxReg    (idxReg),
    .storeData (storeData),
    .accWidth  (accWidth),
    .isWrite   (isWrite),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRd     (memRd),
    .memWe     (memWe),
    .loadData  (loadData)
  );

endmodule

// File: rtl/lane_steer_seq_chk.sv
module lane_steer_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                memRdy,
  input logic [DATA_W-1:0]   memAddr,
  input logic                memRd,
  input logic [DATA_W/8-1:0] memWe,
  input logic                done
);

  logic busBusy;
  assign busBusy = memRd || (memWe != '0);

  // R5: a read never carries write enables
  a_r5_read_no_we: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memWe == '0));

  // R6: the access holds while ready is low
  a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && !memRdy) |=> ($stable(memAddr) && $stable(memRd) && $stable(memWe)));

  // R10: release and completion in the cycle after ready
  a_r10_release_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && memRdy) |=> (!memRd && (memWe == '0) && done));

  // R10: done lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2/R3/R4: only one-hot, paired or full enable shapes
  a_r3_we_shape: assert property (@(posedge clk) disable iff (!rstN)
    (memWe != '0) |-> ($countones(memWe) == 1 || memWe == 4'b0011 ||
                       memWe == 4'b1100 || memWe == 4'b1111));

  // R11: done only appears with the bus already released
  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busBusy);

endmodule

bind lane_steer_seq lane_steer_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memRdy  (memRdy),
  .memAddr (memAddr),
  .memRd   (memRd),
  .memWe   (memWe),
  .done    (done)
);

// File: tb/lane_steer_seq_bench.sv
module lane_steer_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] baseReg = '0;
  logic        useImm = 1'b0;
  logic [15:0] immVal = '0;
  logic [31:0] idxReg = '0;
  logic [31:0] storeData = '0;
  logic [1:0]  accWidth = '0;
  logic        isWrite = 1'b0;
  logic        memRdy = 1'b0;
  logic [31:0] memRdata = '0;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic        memRd;
  logic [3:0]  memWe;
  logic [31:0] loadData;
  logic        done;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;
  bit finished   = 1'b0;

  logic [31:0] mem [0:15];

  always #10 clk = ~clk;  // 50 MHz

  lane_steer_seq u_lane_steer_seq (
    .clk(clk), .rstN(rstN), .start(start), .baseReg(baseReg), .useImm(useImm),
    .immVal(immVal), .idxReg(idxReg), .storeData(storeData), .accWidth(accWidth),
    .isWrite(isWrite), .memRdy(memRdy), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memRd(memRd), .memWe(memWe), .loadData(loadData),
    .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    finished = 1'b1;
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 20000 && !finished) begin
      failCount++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycleCount);
      finishRun();
    end
  end

  // One complete access with independent expected values
  task automatic runAccess(input logic [1:0] w, input logic wr, input logic [31:0] base,
                           input logic selImm, input logic [15:0] imm, input logic [31:0] idx,
                           input logic [31:0] sdata, input int waits, input bit poke);
    logic [31:0] expAddr, expWd, word, expLoad, keepLoad;
    logic [3:0]  expWe;
    expAddr = selImm ? base + {{16{imm[15]}}, imm} : base + idx;
    expWe = 4'b0000;
    expWd = sdata;
    if (wr) begin
      case (w)
        2'd0: begin expWe = 4'b0001 << expAddr[1:0]; expWd = {4{sdata[7:0]}}; end
        2'd1: begin expWe = expAddr[1] ? 4'b1100 : 4'b0011; expWd = {2{sdata[15:0]}}; end
        default: begin expWe = 4'b1111; expWd = sdata; end
      endcase
    end
    keepLoad = loadData;
    @(negedge clk);
    baseReg = base; useImm = selImm; immVal = imm; idxReg = idx;
    storeData = sdata; accWidth = w; isWrite = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 address", memAddr, expAddr);
    check("R5 read strobe", {31'd0, memRd}, {31'd0, !wr});
    check("R2/R3/R4 write enables", {28'd0, memWe}, {28'd0, expWe});
    if (wr) check("R2/R3/R4 write data", memWdata, expWd);
    for (int i = 0; i < waits; i++) begin
      if (poke && i == 0) begin
        baseReg = base ^ 32'h0000_0F00; isWrite = !wr; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      check(poke ? "R11 start ignored addr" : "R6 addr hold", memAddr, expAddr);
      check("R6 enables hold", {27'd0, memRd, memWe}, {27'd0, !wr, expWe});
    end
    word = mem[expAddr[5:2]];
    memRdata = word;
    memRdy = 1'b1;
    @(negedge clk);
    memRdy = 1'b0;
    check("R10 strobes released", {27'd0, memRd, memWe}, 32'd0);
    check("R10 done pulse", {31'd0, done}, 32'd1);
    if (!wr) begin
      case (w)
        2'd0: begin expLoad = (word >> (expAddr[1:0] * 8)) & 32'h0000_00FF;
                    check("R7 byte load", loadData, expLoad); end
        2'd1: begin expLoad = (word >> (expAddr[1] * 16)) & 32'h0000_FFFF;
                    check("R8 half load", loadData, expLoad); end
        default: check("R9 word load", loadData, word);
      endcase
    end else begin
      check("R11 store leaves load value", loadData, keepLoad);
      for (int b = 0; b < 4; b++)
        if (memWe[b] === 1'b0 && expWe[b]) mem[expAddr[5:2]][8*b +: 8] = memWdata[8*b +: 8];
      for (int b = 0; b < 4; b++)
        if (expWe[b]) mem[expAddr[5:2]][8*b +: 8] = expWd[8*b +: 8];
    end
    @(negedge clk);
    check("R10 done one cycle", {31'd0, done}, 32'd0);
    check("R11 idle strobes", {27'd0, memRd, memWe}, 32'd0);
  endtask

  task automatic testReset();
    check("R12 reset addr", memAddr, 32'd0);
    check("R12 reset strobes", {27'd0, memRd, memWe}, 32'd0);
    check("R12 reset done", {31'd0, done}, 32'd0);
    check("R12 reset load", loadData, 32'd0);
  endtask

  task automatic testWord();
    runAccess(2'd2, 1'b1, 32'h0000_0100, 1'b1, 16'h0010, 32'd0, 32'hDEAD_BEEF, 0, 0); // R4
    runAccess(2'd2, 1'b0, 32'h0000_0110, 1'b0, 16'h0000, 32'd0, 32'd0, 1, 0);        // R9
    runAccess(2'd3, 1'b1, 32'h0000_0020, 1'b1, 16'h0004, 32'd0, 32'h1234_5678, 0, 0); // R4 code 3
  endtask

  task automatic testByte();
    for (int k = 0; k < 4; k++)
      runAccess(2'd0, 1'b1, 32'h0000_0040, 1'b1, 16'(k), 32'd0, 32'hFFFF_FF80 + k, 0, 0); // R2
    for (int k = 0; k < 4; k++)
      runAccess(2'd0, 1'b0, 32'h0000_0040, 1'b0, 16'h0, 32'(k), 32'd0, 0, 0);             // R7
    runAccess(2'd0, 1'b0, 32'h0000_0008, 1'b1, 16'h0003, 32'd0, 32'd0, 0, 0);             // R7 high byte
  endtask

  task automatic testHalf();
    runAccess(2'd1, 1'b1, 32'h0000_0084, 1'b1, 16'hFFFE, 32'd0, 32'hAAAA_C3D2, 0, 0); // R3 upper half
    runAccess(2'd1, 1'b1, 32'h0000_0080, 1'b1, 16'h0000, 32'd0, 32'h5555_8001, 0, 0); // R3 lower half
    runAccess(2'd1, 1'b0, 32'h0000_0080, 1'b0, 16'h0, 32'd2, 32'd0, 0, 0);            // R8 upper
    runAccess(2'd1, 1'b0, 32'h0000_0080, 1'b0, 16'h0, 32'd0, 32'd0, 0, 0);            // R8 lower
  endtask

  task automatic testAddressing();
    runAccess(2'd2, 1'b0, 32'h0000_0000, 1'b1, 16'hFFF0, 32'd0, 32'd0, 0, 0);         // R1 wrap below zero
    runAccess(2'd2, 1'b0, 32'hFFFF_FFF0, 1'b0, 16'h0, 32'h0000_0024, 32'd0, 0, 0);    // R1 index wrap
  endtask

  task automatic testWaitAndIgnore();
    runAccess(2'd0, 1'b1, 32'h0000_0030, 1'b1, 16'h0002, 32'd0, 32'h0000_0077, 5, 0); // R6
    runAccess(2'd1, 1'b0, 32'h0000_0030, 1'b1, 16'h0002, 32'd0, 32'd0, 3, 1);         // R11
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h8000_00F1 ^ (i * 32'h0103_0507);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testWord();
    testByte();
    testHalf();
    testAddressing();
    testWaitAndIgnore();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule